// File: doc/BRIEF.md
# Page Access Permission Fault Checker

This block judges one memory access against the attributes of the two lowest translation levels, a directory entry and a leaf entry, and against the processor's protection controls. It reports whether the access must fault, together with a six-bit error code that describes the access and the cause. The directory entry may map a large page on its own, and the leaf entry is then ignored. Walking the tables and raising the exception are left to the surrounding logic.

The decision is purely combinational and is registered once, so the verdict for the inputs presented before a clock edge appears on the outputs just after that edge. The controls cover write protection for supervisor writes, no-execute enable, prevention of supervisor instruction fetches from user pages, and protection keys. The access-disable and write-disable rights of the page's key arrive as two input bits.

Top module: `pfc_fault_unit`

## Requirements
- R1: While reset is high at a clock edge, `fault_o` and `err_o` are zero after that edge.
- R2: The outputs reflect the inputs sampled at the previous clock edge, and `err_o` is all zeros whenever `fault_o` is low.
- R3: Error code layout in a fault report: bit 0 is set unless the faulting entry is not present, bit 1 is set for a write access, bit 2 is set for a user-mode access, bit 3 marks a reserved-bit violation, bit 4 marks an instruction fetch and bit 5 marks a protection-key fault.
- R4: An entry is invalid when it is not present, when its high reserved bit is set, when it is a large-page directory entry with its low reserved bit set, or when its no-execute bit is set while no-execute is disabled. An invalid entry faults; if present it sets bit 3, if absent it clears bit 0. The low reserved bit of a directory entry that does not map a large page has no effect.
- R5: The directory entry is judged first and an invalid directory entry decides the code alone. When the directory entry maps a large page, the leaf inputs have no effect.
- R6: Effective writable and user rights are the AND of both levels (the directory only, for a large page); a user access to a non-user page faults, and a write to a non-writable page faults unless R7 excuses it.
- R7: A supervisor write to a read-only page is allowed when write protection is off; user writes are never excused.
- R8: A fetch faults when the no-execute bit is set at either level in use.
- R9: A supervisor fetch from a user page faults when supervisor-execute prevention is on; a user-mode fetch is not affected by that control.
- R10: With protection keys enabled, a non-fetch access to a user page faults with bit 5 when access-disable is set, or when write-disable is set on a write not excused by R7. Keys have no effect on fetches, on supervisor pages, or when keys are disabled.
- R11: Bit 4 is forced to zero when both no-execute and supervisor-execute prevention are disabled.
- R12: Access kind encoding on `acc_kind_i`: 2'b00 read, 2'b01 write, 2'b10 fetch; 2'b11 is handled as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_present_i | input | 1 | Directory entry present |
| dir_write_i | input | 1 | Directory entry allows writes |
| dir_user_i | input | 1 | Directory entry allows user access |
| dir_nx_i | input | 1 | Directory entry no-execute |
| dir_hi_rsvd_i | input | 1 | Directory entry high reserved bit |
| dir_large_i | input | 1 | Directory entry maps a large page |
| dir_lo_rsvd_i | input | 1 | Directory entry low reserved bit (large pages only) |
| leaf_present_i | input | 1 | Leaf entry present |
| leaf_write_i | input | 1 | Leaf entry allows writes |
| leaf_user_i | input | 1 | Leaf entry allows user access |
| leaf_nx_i | input | 1 | Leaf entry no-execute |
| leaf_hi_rsvd_i | input | 1 | Leaf entry high reserved bit |
| acc_user_i | input | 1 | Access made in user mode |
| acc_kind_i | input | 2 | Access kind (R12) |
| wp_en_i | input | 1 | Write protection for supervisor writes |
| nx_en_i | input | 1 | No-execute enable |
| sxp_en_i | input | 1 | Supervisor-execute prevention enable |
| pk_en_i | input | 1 | Protection keys enable |
| key_ad_i | input | 1 | Access-disable right of the page's key |
| key_wd_i | input | 1 | Write-disable right of the page's key |
| fault_o | output | 1 | Access must fault |
| err_o | output | 6 | Error code (R3), zero without a fault |

## Verification
Every result of this block, the fault flag and all six error bits alike, is due exactly one clock edge after the inputs are applied, since a single register sits between the decision logic and the ports. The bench drives each stimulus on a falling edge and samples both outputs on the next falling edge, half a cycle after the register updates. The latency check also samples on the driving falling edge itself to confirm the previous verdict is still held there.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int ERR_W  = 6;
    localparam int KIND_W = 2;

    localparam int EB_PRESENT = 0;
    localparam int EB_WRITE   = 1;
    localparam int EB_USER    = 2;
    localparam int EB_RSVD    = 3;
    localparam int EB_FETCH   = 4;
    localparam int EB_PKEY    = 5;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ     = 2'b00,
        ACC_WRITE    = 2'b01,
        ACC_FETCH    = 2'b10,
        ACC_ALT_READ = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic is_user;
        logic is_write;
        logic is_fetch;
    } access_t;

    typedef struct packed {
        logic writable;
        logic user;
        logic exec;
    } rights_t;

    typedef struct packed {
        logic valid;
        logic rsvd;
        logic absent;
    } lvl_status_t;

    function automatic access_t decode_access(input logic usr, input acc_kind_e kind);
        access_t a;
        a.is_user  = usr;
        a.is_write = (kind == ACC_WRITE);
        a.is_fetch = (kind == ACC_FETCH);
        return a;
    endfunction

    function automatic logic [ERR_W-1:0] build_code(
        input access_t a, input logic absent, input logic rsvd,
        input logic fetch_shown, input logic key_hit);
        logic [ERR_W-1:0] c;
        c = '0;
        c[EB_PRESENT] = ~absent;
        c[EB_WRITE]   = a.is_write;
        c[EB_USER]    = a.is_user;
        c[EB_RSVD]    = rsvd;
        c[EB_FETCH]   = a.is_fetch & fetch_shown;
        c[EB_PKEY]    = key_hit;
        return c;
    endfunction

endpackage

// File: rtl/pfc_level_check.sv
module pfc_level_check
    import pfc_pkg::*;
(
    input  logic        present,
    input  logic        hi_rsvd,
    input  logic        size_rsvd,
    input  logic        nx,
    input  logic        nx_en,
    output lvl_status_t status
);

    logic bad_bits;

    always_comb begin
        bad_bits      = hi_rsvd | size_rsvd | (nx & ~nx_en);
        status.valid  = present & ~bad_bits;
        status.rsvd   = present & bad_bits;
        status.absent = ~present;
    end

endmodule

// File: rtl/pfc_rights_merge.sv
module pfc_rights_merge
    import pfc_pkg::*;
(
    input  logic    dir_w,
    input  logic    dir_u,
    input  logic    dir_nx,
    input  logic    leaf_w,
    input  logic    leaf_u,
    input  logic    leaf_nx,
    input  logic    leaf_used,
    output rights_t rights
);

    always_comb begin
        if (leaf_used) begin
            rights.writable = dir_w & leaf_w;
            rights.user     = dir_u & leaf_u;
            rights.exec     = ~dir_nx & ~leaf_nx;
        end else begin
            rights.writable = dir_w;
            rights.user     = dir_u;
            rights.exec     = ~dir_nx;
        end
    end

endmodule

// File: rtl/pfc_perm_eval.sv
module pfc_perm_eval
    import pfc_pkg::*;
(
    input  rights_t rights,
    input  access_t acc,
    input  logic    wp_en,
    input  logic    sxp_en,
    input  logic    pk_en,
    input  logic    key_ad,
    input  logic    key_wd,
    output logic    perm_fault,
    output logic    key_fault
);

    logic wr_excused;
    logic user_deny;
    logic write_deny;
    logic exec_deny;
    logic sxp_deny;
    logic key_gate;

    always_comb begin
        wr_excused = ~wp_en & ~acc.is_user;
        user_deny  = acc.is_user & ~rights.user;
        write_deny = acc.is_write & ~rights.writable & ~wr_excused;
        exec_deny  = acc.is_fetch & ~rights.exec;
        sxp_deny   = acc.is_fetch & ~acc.is_user & rights.user & sxp_en;
        perm_fault = user_deny | write_deny | exec_deny | sxp_deny;

        key_gate   = pk_en & rights.user & ~acc.is_fetch;
        key_fault  = key_gate & (key_ad | (acc.is_write & key_wd & ~wr_excused));
    end

endmodule

// File: rtl/pfc_fault_unit.sv
module pfc_fault_unit
    import pfc_pkg::*;
#(
    parameter int CODE_W = pfc_pkg::ERR_W,
    parameter int KW     = pfc_pkg::KIND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_present_i,
    input  logic              dir_write_i,
    input  logic              dir_user_i,
    input  logic              dir_nx_i,
    input  logic              dir_hi_rsvd_i,
    input  logic              dir_large_i,
    input  logic              dir_lo_rsvd_i,
    input  logic              leaf_present_i,
    input  logic              leaf_write_i,
    input  logic              leaf_user_i,
    input  logic              leaf_nx_i,
    input  logic              leaf_hi_rsvd_i,
    input  logic              acc_user_i,
    input  logic [KW-1:0]     acc_kind_i,
    input  logic              wp_en_i,
    input  logic              nx_en_i,
    input  logic              sxp_en_i,
    input  logic              pk_en_i,
    input  logic              key_ad_i,
    input  logic              key_wd_i,
    output logic              fault_o,
    output logic [CODE_W-1:0] err_o
);

    access_t          acc;
    lvl_status_t      dir_st;
    lvl_status_t      leaf_st;
    rights_t          rights;
    logic             leaf_used;
    logic             perm_f;
    logic             key_f;
    logic             fault_n;
    logic             rsvd_n;
    logic             absent_n;
    logic             key_n;
    logic             fetch_shown;
    logic [ERR_W-1:0] code_n;
    logic             fault_q;
    logic [ERR_W-1:0] err_q;

    assign acc       = decode_access(acc_user_i, acc_kind_e'(acc_kind_i));
    assign leaf_used = ~dir_large_i;

    pfc_level_check u_dir_chk (
        .present   (dir_present_i),
        .hi_rsvd   (dir_hi_rsvd_i),
        .size_rsvd (dir_large_i & dir_lo_rsvd_i),
        .nx        (dir_nx_i),
        .nx_en     (nx_en_i),
        .status    (dir_st)
    );

    pfc_level_check u_leaf_chk (
        .present   (leaf_present_i),
        .hi_rsvd   (leaf_hi_rsvd_i),
        .size_rsvd (1'b0),
        .nx        (leaf_nx_i),
        .nx_en     (nx_en_i),
        .status    (leaf_st)
    );

    pfc_rights_merge u_merge (
        .dir_w     (dir_write_i),
        .dir_u     (dir_user_i),
        .dir_nx    (dir_nx_i),
        .leaf_w    (leaf_write_i),
        .leaf_u    (leaf_user_i),
        .leaf_nx   (leaf_nx_i),
        .leaf_used (leaf_used),
        .rights    (rights)
    );

    pfc_perm_eval u_perm (
        .rights     (rights),
        .acc        (acc),
        .wp_en      (wp_en_i),
        .sxp_en     (sxp_en_i),
        .pk_en      (pk_en_i),
        .key_ad     (key_ad_i),
        .key_wd     (key_wd_i),
        .perm_fault (perm_f),
        .key_fault  (key_f)
    );

    // Directory first, then leaf (only for small pages), then rights.
    always_comb begin
        fault_n  = 1'b0;
        rsvd_n   = 1'b0;
        absent_n = 1'b0;
        key_n    = 1'b0;
        if (!dir_st.valid) begin
            fault_n  = 1'b1;
            rsvd_n   = dir_st.rsvd;
            absent_n = dir_st.absent;
        end else if (leaf_used && !leaf_st.valid) begin
            fault_n  = 1'b1;
            rsvd_n   = leaf_st.rsvd;
            absent_n = leaf_st.absent;
        end else begin
            fault_n  = perm_f | key_f;
            key_n    = key_f;
        end
        fetch_shown = nx_en_i | sxp_en_i;
        code_n = fault_n ? build_code(acc, absent_n, rsvd_n, fetch_shown, key_n)
                         : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            err_q   <= '0;
        end else begin
            fault_q <= fault_n;
            err_q   <= code_n;
        end
    end

    assign fault_o = fault_q;
    assign err_o   = CODE_W'(err_q);

endmodule

// File: rtl/pfc_fault_unit_chk.sv
module pfc_fault_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       dir_present_i,
    input logic       dir_hi_rsvd_i,
    input logic       acc_user_i,
    input logic [1:0] acc_kind_i,
    input logic       nx_en_i,
    input logic       sxp_en_i,
    input logic       pk_en_i,
    input logic       fault_o,
    input logic [5:0] err_o
);

    logic armed;

    always_ff @(posedge clk) begin
        armed <= !rst;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!fault_o && err_o == 6'd0));

    // R2
    quiet_code_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> err_o == 6'd0);

    // R4
    dir_absent_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(!dir_present_i)) |-> (fault_o && !err_o[0] && !err_o[3]));

    // R4
    dir_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(dir_present_i && dir_hi_rsvd_i)) |-> (fault_o && err_o[3] && err_o[0]));

    // R3
    user_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && fault_o) |-> (err_o[2] == $past(acc_user_i)));

    // R3
    write_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && fault_o) |-> (err_o[1] == ($past(acc_kind_i) == 2'b01)));

    // R11
    fetch_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(!nx_en_i && !sxp_en_i)) |-> !err_o[4]);

    // R10
    key_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && err_o[5]) |-> ($past(pk_en_i) && $past(acc_kind_i) != 2'b10));

endmodule

bind pfc_fault_unit pfc_fault_unit_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .dir_present_i (dir_present_i),
    .dir_hi_rsvd_i (dir_hi_rsvd_i),
    .acc_user_i    (acc_user_i),
    .acc_kind_i    (acc_kind_i),
    .nx_en_i       (nx_en_i),
    .sxp_en_i      (sxp_en_i),
    .pk_en_i       (pk_en_i),
    .fault_o       (fault_o),
    .err_o         (err_o)
);

// File: tb/pfc_fault_unit_tb_top.sv
`timescale 1ns/1ps
module pfc_fault_unit_tb_top;

    typedef struct {
        logic dp, dw, du, dnx, dhi, dlg, dlo;
        logic lp, lw, lu, lnx, lhi;
        logic usr;
        logic [1:0] kind;
        logic wp, nxe, sxp, pke, ad, wd;
    } stim_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_present_i, dir_write_i, dir_user_i, dir_nx_i;
    logic       dir_hi_rsvd_i, dir_large_i, dir_lo_rsvd_i;
    logic       leaf_present_i, leaf_write_i, leaf_user_i, leaf_nx_i, leaf_hi_rsvd_i;
    logic       acc_user_i;
    logic [1:0] acc_kind_i;
    logic       wp_en_i, nx_en_i, sxp_en_i, pk_en_i, key_ad_i, key_wd_i;
    logic       fault_o;
    logic [5:0] err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pfc_fault_unit dut_i (
        .clk(clk), .rst(rst),
        .dir_present_i(dir_present_i), .dir_write_i(dir_write_i),
        .dir_user_i(dir_user_i), .dir_nx_i(dir_nx_i),
        .dir_hi_rsvd_i(dir_hi_rsvd_i), .dir_large_i(dir_large_i),
        .dir_lo_rsvd_i(dir_lo_rsvd_i),
        .leaf_present_i(leaf_present_i), .leaf_write_i(leaf_write_i),
        .leaf_user_i(leaf_user_i), .leaf_nx_i(leaf_nx_i),
        .leaf_hi_rsvd_i(leaf_hi_rsvd_i),
        .acc_user_i(acc_user_i), .acc_kind_i(acc_kind_i),
        .wp_en_i(wp_en_i), .nx_en_i(nx_en_i), .sxp_en_i(sxp_en_i),
        .pk_en_i(pk_en_i), .key_ad_i(key_ad_i), .key_wd_i(key_wd_i),
        .fault_o(fault_o), .err_o(err_o)
    );

    function automatic stim_t base();
        stim_t s;
        s.dp = 1; s.dw = 1; s.du = 1; s.dnx = 0; s.dhi = 0; s.dlg = 0; s.dlo = 0;
        s.lp = 1; s.lw = 1; s.lu = 1; s.lnx = 0; s.lhi = 0;
        s.usr = 0; s.kind = 2'b00;
        s.wp = 1; s.nxe = 1; s.sxp = 0; s.pke = 0; s.ad = 0; s.wd = 0;
        return s;
    endfunction

    task automatic put(input stim_t s);
        dir_present_i = s.dp; dir_write_i = s.dw; dir_user_i = s.du;
        dir_nx_i = s.dnx; dir_hi_rsvd_i = s.dhi; dir_large_i = s.dlg;
        dir_lo_rsvd_i = s.dlo;
        leaf_present_i = s.lp; leaf_write_i = s.lw; leaf_user_i = s.lu;
        leaf_nx_i = s.lnx; leaf_hi_rsvd_i = s.lhi;
        acc_user_i = s.usr; acc_kind_i = s.kind;
        wp_en_i = s.wp; nx_en_i = s.nxe; sxp_en_i = s.sxp;
        pk_en_i = s.pke; key_ad_i = s.ad; key_wd_i = s.wd;
    endtask

    task automatic compare(input logic ef, input logic [5:0] ee, input string tag);
        n_checks++;
        if (fault_o !== ef || err_o !== ee) begin
            n_fails++;
            $display("FAIL %s: fault=%0b err=%02h expected fault=%0b err=%02h",
                     tag, fault_o, err_o, ef, ee);
        end
    endtask

    // Drive on a falling edge; the register captures at the next rising
    // edge; sample on the falling edge after it.
    task automatic run(input stim_t s, input logic ef, input logic [5:0] ee,
                       input string tag);
        @(negedge clk);
        put(s);
        @(posedge clk);
        @(negedge clk);
        compare(ef, ee, tag);
    endtask

    task automatic t_reset();
        stim_t s = base();
        s.dp = 0;
        put(s);
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(1'b0, 6'h00, "R1 outputs cleared in reset");
        rst = 0;
    endtask

    task automatic t_latency();
        stim_t s = base();
        run(s, 1'b0, 6'h00, "R2 allowed supervisor read");
        s.dp = 0;
        @(negedge clk);
        put(s);
        #0.5;
        compare(1'b0, 6'h00, "R2 previous verdict held before edge");
        @(posedge clk);
        @(negedge clk);
        compare(1'b1, 6'h00, "R2 verdict one edge later");
        s = base();
        s.usr = 1; s.kind = 2'b01;
        run(s, 1'b0, 6'h00, "R2 code zero on allowed user write");
    endtask

    task automatic t_invalid();
        stim_t s = base();
        s.dp = 0; s.usr = 1; s.kind = 2'b01;
        run(s, 1'b1, 6'h06, "R4 R3 absent directory, user write");
        s = base(); s.lp = 0;
        run(s, 1'b1, 6'h00, "R4 absent leaf");
        s = base(); s.dhi = 1;
        run(s, 1'b1, 6'h09, "R4 directory high reserved");
        s = base(); s.dlg = 1; s.dlo = 1;
        run(s, 1'b1, 6'h09, "R4 large page low reserved");
        s = base(); s.dlo = 1;
        run(s, 1'b0, 6'h00, "R4 low reserved ignored on small page");
        s = base(); s.dnx = 1; s.nxe = 0;
        run(s, 1'b1, 6'h09, "R4 directory nx with nx disabled");
        s = base(); s.lhi = 1;
        run(s, 1'b1, 6'h09, "R4 leaf high reserved");
    endtask

    task automatic t_levels();
        stim_t s = base();
        s.dlg = 1; s.lp = 0; s.lhi = 1; s.lu = 0;
        run(s, 1'b0, 6'h00, "R5 leaf ignored for large page");
        s = base(); s.dp = 0; s.lhi = 1;
        run(s, 1'b1, 6'h00, "R5 directory decides before leaf");
    endtask

    task automatic t_rights();
        stim_t s = base();
        s.usr = 1; s.lu = 0;
        run(s, 1'b1, 6'h05, "R6 leaf denies user");
        s = base(); s.usr = 1; s.du = 0;
        run(s, 1'b1, 6'h05, "R6 directory denies user");
        s = base(); s.usr = 1; s.kind = 2'b01; s.lw = 0;
        run(s, 1'b1, 6'h07, "R6 user write to read-only");
    endtask

    task automatic t_wp();
        stim_t s = base();
        s.kind = 2'b01; s.lw = 0;
        run(s, 1'b1, 6'h03, "R7 supervisor write read-only, protect on");
        s.wp = 0;
        run(s, 1'b0, 6'h00, "R7 supervisor write read-only, protect off");
        s.usr = 1;
        run(s, 1'b1, 6'h07, "R7 user write never excused");
    endtask

    task automatic t_nx();
        stim_t s = base();
        s.kind = 2'b10; s.lnx = 1;
        run(s, 1'b1, 6'h11, "R8 fetch from leaf nx");
        s = base(); s.kind = 2'b10; s.dnx = 1;
        run(s, 1'b1, 6'h11, "R8 fetch from directory nx");
    endtask

    task automatic t_sxp();
        stim_t s = base();
        s.kind = 2'b10; s.sxp = 1;
        run(s, 1'b1, 6'h11, "R9 supervisor fetch user page");
        s.sxp = 0;
        run(s, 1'b0, 6'h00, "R9 prevention off");
        s.sxp = 1; s.lu = 0;
        run(s, 1'b0, 6'h00, "R9 supervisor page allowed");
        s = base(); s.kind = 2'b10; s.sxp = 1; s.usr = 1;
        run(s, 1'b0, 6'h00, "R9 user fetch unaffected");
    endtask

    task automatic t_keys();
        stim_t s = base();
        s.pke = 1; s.ad = 1;
        run(s, 1'b1, 6'h21, "R10 access-disable supervisor read");
        s.usr = 1;
        run(s, 1'b1, 6'h25, "R10 access-disable user read");
        s = base(); s.pke = 1; s.wd = 1; s.usr = 1; s.kind = 2'b01;
        run(s, 1'b1, 6'h27, "R10 write-disable user write");
        s.usr = 0; s.wp = 0;
        run(s, 1'b0, 6'h00, "R10 write-disable excused by protect off");
        s.wp = 1;
        run(s, 1'b1, 6'h23, "R10 write-disable supervisor write");
        s.kind = 2'b00; s.usr = 1;
        run(s, 1'b0, 6'h00, "R10 write-disable read allowed");
        s = base(); s.ad = 1;
        run(s, 1'b0, 6'h00, "R10 keys disabled");
        s = base(); s.pke = 1; s.ad = 1; s.kind = 2'b10;
        run(s, 1'b0, 6'h00, "R10 fetch not subject to keys");
        s = base(); s.pke = 1; s.ad = 1; s.lu = 0;
        run(s, 1'b0, 6'h00, "R10 supervisor page not subject to keys");
    endtask

    task automatic t_fetch_mask();
        stim_t s = base();
        s.nxe = 0; s.kind = 2'b10; s.lp = 0;
        run(s, 1'b1, 6'h00, "R11 fetch bit masked");
        s.sxp = 1;
        run(s, 1'b1, 6'h10, "R11 fetch bit shown with prevention on");
        s = base(); s.nxe = 0; s.kind = 2'b10; s.dnx = 1;
        run(s, 1'b1, 6'h09, "R11 masked on reserved fault");
    endtask

    task automatic t_kind();
        stim_t s = base();
        s.kind = 2'b11; s.lnx = 1; s.lw = 0;
        run(s, 1'b0, 6'h00, "R12 code 3 acts as read");
        s = base(); s.kind = 2'b11; s.usr = 1; s.lu = 0;
        run(s, 1'b1, 6'h05, "R12 code 3 faults as read");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        put(base());
        t_reset();
        t_latency();
        t_invalid();
        t_levels();
        t_rights();
        t_wp();
        t_nx();
        t_sxp();
        t_keys();
        t_fetch_mask();
        t_kind();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

endmodule